// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a small, byte-wide, directly addressed register port reach a much larger space of 32-bit registers that sit behind a 16-bit word address. The host loads four data bytes and two address bytes into a direct window. It then writes a control byte, and that write launches a single read or write on an internal request/acknowledge bus. A busy flag in the control byte stays set while the transaction is in flight. When it drops, the host reads the returned data and a six-bit completion code.

The upper byte of the indirect address picks one of a fixed number of functional sub-blocks, each spanning 0x100 words. The bridge decodes this byte into a one-hot select for the sub-blocks. A request to an address whose upper byte names no populated sub-block never reaches the bus and is reported as an error. A missing acknowledge is caught by a cycle timeout.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset every direct register reads 0, the busy flag (control bit 7) is 0, and no bus request is issued.
- R2: Direct offsets 0x30, 0x31, 0x32 and 0x33 hold data bits 7:0, 15:8, 23:16 and 31:24. Offset 0x34 holds address bits 7:0 and offset 0x35 holds address bits 15:8. Each one reads back what was last written to it while idle.
- R3: A write to offset 0x3F with bit 6 = 0 while idle launches an indirect write. In the cycle after that write, bus_req is high for exactly one cycle, with bus_wr = 1, bus_addr equal to the held address, and bus_wdata equal to the held data.
- R4: A write to offset 0x3F with bit 6 = 1 while idle launches an indirect read (bus_wr = 0). After the acknowledge, offsets 0x30 to 0x33 return bus_rdata as it was on the acknowledge cycle.
- R5: Control bit 7 reads 1 from the cycle after the launching write. It reads 0 in the cycle after the cycle in which bus_ack was sampled high, and the error code (control bits 5:0) is then 0.
- R6: While busy, host writes to the control, data and address offsets are ignored. No second request is issued and the pending data is not altered.
- R7: While busy, bus_sel has exactly bit N set, where N is address bits 15:8, for N from 0 to 9. It is all zero while idle.
- R8: If address bits 15:8 exceed 9, no bus request is issued, the error code becomes 1, and busy clears one cycle after launch.
- R9: If no acknowledge arrives in the request cycle or in the 64 cycles after it (the TMO_CYC default), the error code becomes 2, busy clears, and the data registers keep their prior values. An acknowledge in the last of those cycles still completes with code 0.
- R10: The error code reads 0 while a new transaction is busy. Control bits 7 and 5:0 cannot be written by the host: they read as busy and code, whatever value was written.
- R11: bus_ack while idle has no effect on the data registers or the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Direct write strobe |
| host_addr | input | 8 | Direct register offset |
| host_wdata | input | 8 | Direct write byte |
| host_rdata | output | 8 | Byte at host_addr (combinational) |
| bus_req | output | 1 | One-cycle internal request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Indirect word address |
| bus_wdata | output | 32 | Write data |
| bus_sel | output | 10 | One-hot sub-block select |
| bus_ack | input | 1 | Completion from the sub-block |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
If the sequencer gets stuck in a busy state, the control byte keeps reading bit 7 set. That shows on the very next host read, and the timeout check catches it within 65 cycles. If the byte lanes or the read capture are wrong, data comes back out of order right after the acknowledge. A wrong decode shows up in bus_sel during the request cycle, or as a request that should not have been issued. The scoreboard flags that request in the same cycle.

// File: rtl/irb_pkg.sv
package irb_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} irb_state_e;

   localparam logic [5:0] CODE_OK    = 6'd0;
   localparam logic [5:0] CODE_NOBLK = 6'd1;
   localparam logic [5:0] CODE_TMO   = 6'd2;

   localparam int OFS_DATA = 'h30;
   localparam int OFS_ADDR = 'h34;
   localparam int OFS_CTRL = 'h3F;
   localparam int CTRL_RD_BIT = 6;
endpackage

// File: rtl/irb_sel_decode.sv
module irb_sel_decode #(
   parameter int BLK_W   = 8,
   parameter int NUM_BLK = 10
) (
   input  logic [BLK_W-1:0]   blk,
   input  logic               en,
   output logic [NUM_BLK-1:0] sel,
   output logic               hit
);
   if (NUM_BLK < 1 || NUM_BLK > (1 << BLK_W)) begin : g_bad_cnt
      $error("irb_sel_decode: NUM_BLK out of range for BLK_W");
   end

   logic [NUM_BLK-1:0] match;

   for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
      assign match[i] = (blk == BLK_W'(i));
      assign sel[i]   = en & match[i];
   end

   assign hit = |match;
endmodule

// File: rtl/irb_txn_ctrl.sv
module irb_txn_ctrl
   import irb_pkg::*;
#(
   parameter int TMO_CYC = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  logic       launch_rd,
   input  logic       addr_ok,
   input  logic       bus_ack,
   output logic       busy,
   output logic       rnw,
   output logic       bus_req,
   output logic       rd_load,
   output logic [5:0] code
);
   localparam int CNT_W = $clog2(TMO_CYC + 1);

   if (TMO_CYC < 1) begin : g_bad_tmo
      $error("irb_txn_ctrl: TMO_CYC must be at least 1");
   end

   irb_state_e       state;
   logic [CNT_W-1:0] wait_cnt;
   logic             ack_ok;

   assign busy    = (state != ST_IDLE);
   assign bus_req = (state == ST_REQ) && addr_ok;
   assign ack_ok  = bus_ack && (bus_req || state == ST_WAIT);
   assign rd_load = ack_ok && rnw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         wait_cnt <= '0;
         code     <= CODE_OK;
         rnw      <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (launch) begin
                  state <= ST_REQ;
                  code  <= CODE_OK;
                  rnw   <= launch_rd;
               end
            end
            ST_REQ: begin
               if (!addr_ok) begin
                  code  <= CODE_NOBLK;
                  state <= ST_IDLE;
               end else if (ack_ok) begin
                  state <= ST_IDLE;
               end else begin
                  state    <= ST_WAIT;
                  wait_cnt <= '0;
               end
            end
            ST_WAIT: begin
               if (ack_ok) begin
                  state <= ST_IDLE;
               end else if (wait_cnt == CNT_W'(TMO_CYC - 1)) begin
                  code  <= CODE_TMO;
                  state <= ST_IDLE;
               end else begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
   import irb_pkg::*;
#(
   parameter int HOST_AW = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 16,
   parameter int BLK_W   = 8,
   parameter int NUM_BLK = 10,
   parameter int TMO_CYC = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [7:0]         host_wdata,
   output logic [7:0]         host_rdata,
   output logic               bus_req,
   output logic               bus_wr,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   output logic [NUM_BLK-1:0] bus_sel,
   input  logic               bus_ack,
   input  logic [DATA_W-1:0]  bus_rdata
);
   localparam int DBYTES = DATA_W / 8;
   localparam int ABYTES = ADDR_W / 8;

   if (DATA_W % 8 != 0 || ADDR_W % 8 != 0) begin : g_bad_w
      $error("ind_reg_bridge: widths must be whole bytes");
   end
   if (BLK_W > ADDR_W) begin : g_bad_blk
      $error("ind_reg_bridge: BLK_W wider than ADDR_W");
   end

   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] addr_q;
   logic              busy, rnw, rd_load, addr_ok, launch, wr_ok;
   logic [5:0]        code;

   assign wr_ok  = host_wr && !busy;
   assign launch = wr_ok && (host_addr == HOST_AW'(OFS_CTRL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         addr_q <= '0;
      end else begin
         if (rd_load) begin
            data_q <= bus_rdata;
         end else if (wr_ok) begin
            for (int i = 0; i < DBYTES; i++) begin
               if (host_addr == HOST_AW'(OFS_DATA + i)) data_q[8*i +: 8] <= host_wdata;
            end
         end
         if (wr_ok) begin
            for (int j = 0; j < ABYTES; j++) begin
               if (host_addr == HOST_AW'(OFS_ADDR + j)) addr_q[8*j +: 8] <= host_wdata;
            end
         end
      end
   end

   always_comb begin
      host_rdata = 8'h00;
      for (int i = 0; i < DBYTES; i++) begin
         if (host_addr == HOST_AW'(OFS_DATA + i)) host_rdata = data_q[8*i +: 8];
      end
      for (int j = 0; j < ABYTES; j++) begin
         if (host_addr == HOST_AW'(OFS_ADDR + j)) host_rdata = addr_q[8*j +: 8];
      end
      if (host_addr == HOST_AW'(OFS_CTRL)) host_rdata = {busy, rnw, code};
   end

   irb_sel_decode #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK)) u_dec (
      .blk (addr_q[ADDR_W-1 -: BLK_W]),
      .en  (busy),
      .sel (bus_sel),
      .hit (addr_ok)
   );

   irb_txn_ctrl #(.TMO_CYC(TMO_CYC)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .launch_rd (host_wdata[CTRL_RD_BIT]),
      .addr_ok   (addr_ok),
      .bus_ack   (bus_ack),
      .busy      (busy),
      .rnw       (rnw),
      .bus_req   (bus_req),
      .rd_load   (rd_load),
      .code      (code)
   );

   assign bus_wr    = !rnw;
   assign bus_addr  = addr_q;
   assign bus_wdata = data_q;
endmodule

// File: rtl/irb_checker.sv
module irb_checker #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 16,
   parameter int NUM_BLK = 10,
   parameter int TMO_CYC = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               bus_req,
   input logic               bus_ack,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [NUM_BLK-1:0] bus_sel,
   input logic [5:0]         code
);
   logic [31:0] since_req;

   always_ff @(posedge clk) begin
      if (!rst_n)       since_req <= '0;
      else if (bus_req) since_req <= '0;
      else if (busy)    since_req <= since_req + 1;
      else              since_req <= '0;
   end

   assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> !bus_req);
   assert_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> busy);
   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_ack && !$rose(busy)) |=> !busy);
   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_wdata)));
   assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_sel));
   assert_sel_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus_sel == '0));
   assert_req_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> ($countones(bus_sel) == 1));
   assert_bounded_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (since_req < 32'(TMO_CYC)));
   assert_code_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (code == 6'd0));
endmodule

bind ind_reg_bridge irb_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .TMO_CYC(TMO_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .bus_req   (bus_req),
   .bus_ack   (bus_ack),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_sel   (bus_sel),
   .code      (code)
);

// File: tb/tb_ind_reg_bridge.sv
module tb_ind_reg_bridge;
   localparam int TMO = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_addr = 8'h00;
   logic [7:0]  host_wdata = 8'h00;
   logic [7:0]  host_rdata;
   logic        bus_req, bus_wr;
   logic [15:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [9:0]  bus_sel;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   int checks = 0;
   int errors = 0;
   logic [48:0] exp_q[$];

   always #5 clk = ~clk;

   ind_reg_bridge dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_req(bus_req),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_sel(bus_sel), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: every request is compared against the scoreboard queue (R3, R4, R6, R8)
   always @(negedge clk) begin
      if (rst_n && bus_req) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6/R8 unexpected request", {15'd0, bus_wr, bus_addr, bus_wdata}, 64'd0);
         end else begin
            logic [48:0] e;
            e = exp_q.pop_front();
            chk({bus_wr, bus_addr, bus_wdata} == e, "R3/R4 request fields",
                {15'd0, bus_wr, bus_addr, bus_wdata}, {15'd0, e});
         end
      end
   end

   task automatic hwr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hrd(input logic [7:0] a, output logic [7:0] d);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic load(input logic [15:0] a, input logic [31:0] d);
      for (int i = 0; i < 4; i++) hwr(8'h30 + 8'(i), d[8*i +: 8]);
      hwr(8'h34, a[7:0]);
      hwr(8'h35, a[15:8]);
   endtask

   task automatic rd32(output logic [31:0] v);
      for (int i = 0; i < 4; i++) begin
         logic [7:0] b;
         hrd(8'h30 + 8'(i), b);
         v[8*i +: 8] = b;
      end
   endtask

   // launch, then acknowledge after dly cycles; ends one negedge after the ack cycle
   task automatic txn(input logic [15:0] a, input logic [31:0] d, input bit rd,
                      input int dly, input logic [31:0] rdat);
      logic [7:0] c;
      load(a, d);
      exp_q.push_back({~rd, a, d});
      hwr(8'h3F, rd ? 8'h40 : 8'h00);
      hrd(8'h3F, c);
      chk(c == {1'b1, rd, 6'd0}, "R5 busy after launch", c, {1'b1, rd, 6'd0});
      chk(bus_sel == (10'd1 << a[15:8]), "R7 select", bus_sel, 10'd1 << a[15:8]);
      for (int k = 0; k < dly; k++) @(negedge clk);
      bus_ack = 1'b1; bus_rdata = rdat;
      @(negedge clk);
      bus_ack = 1'b0; bus_rdata = 32'hDEAD_BEEF;
      hrd(8'h3F, c);
      chk(c == {1'b0, rd, 6'd0}, "R5 done code 0", c, {1'b0, rd, 6'd0});
      chk(bus_sel == 10'd0, "R7 select idle", bus_sel, 0);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0]  c;
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd32(v);
      chk(v == 0, "R1 data reset", v, 0);
      hrd(8'h35, c); chk(c == 0, "R1 addr reset", c, 0);
      hrd(8'h3F, c); chk(c == 0, "R1 ctrl reset", c, 0);
      chk(bus_req == 0, "R1 no request", bus_req, 0);

      // R2 byte lanes
      load(16'hA55A, 32'h1122_3344);
      rd32(v); chk(v == 32'h1122_3344, "R2 data lanes", v, 32'h1122_3344);
      hrd(8'h34, c); chk(c == 8'h5A, "R2 addr low", c, 8'h5A);
      hrd(8'h35, c); chk(c == 8'hA5, "R2 addr high", c, 8'hA5);

      // R3 write, immediate ack
      txn(16'h0312, 32'hCAFE_0001, 1'b0, 0, 32'h0);
      rd32(v); chk(v == 32'hCAFE_0001, "R3 data kept after write", v, 32'hCAFE_0001);

      // R4 read, ack after 3 cycles, sub-block 9
      txn(16'h09FF, 32'h0, 1'b1, 3, 32'h8765_4321);
      rd32(v); chk(v == 32'h8765_4321, "R4 read data", v, 32'h8765_4321);

      // R9 boundary: ack in last allowed cycle, block 0
      txn(16'h0004, 32'h0BAD_F00D, 1'b0, TMO, 32'h0);

      // R11 ack while idle ignored
      @(negedge clk);
      bus_ack = 1'b1; bus_rdata = 32'h5555_AAAA;
      @(negedge clk);
      bus_ack = 1'b0;
      rd32(v); chk(v == 32'h0BAD_F00D, "R11 idle ack data", v, 32'h0BAD_F00D);
      hrd(8'h3F, c); chk(c == 8'h00, "R11 idle ack ctrl", c, 8'h00);

      // R6 writes while busy ignored; R10 read-only bits
      load(16'h0120, 32'h0000_0000);
      exp_q.push_back({1'b0, 16'h0120, 32'h0});
      hwr(8'h3F, 8'hFF);
      hrd(8'h3F, c); chk(c == 8'hC0, "R10 ctrl read-only bits", c, 8'hC0);
      hwr(8'h3F, 8'h00);
      hwr(8'h30, 8'hAA);
      hwr(8'h35, 8'h07);
      hrd(8'h35, c); chk(c == 8'h01, "R6 addr write ignored", c, 8'h01);
      bus_ack = 1'b1; bus_rdata = 32'h1357_9BDF;
      @(negedge clk);
      bus_ack = 1'b0;
      rd32(v); chk(v == 32'h1357_9BDF, "R6 read data not corrupted", v, 32'h1357_9BDF);
      hrd(8'h3F, c); chk(c == 8'h40, "R6 single completion", c, 8'h40);

      // R8 unpopulated sub-block
      load(16'h0A00, 32'h7777_7777);
      hwr(8'h3F, 8'h40);
      hrd(8'h3F, c); chk(c == 8'hC0, "R8 busy in check cycle", c, 8'hC0);
      @(negedge clk);
      hrd(8'h3F, c); chk(c == 8'h41, "R8 code 1", c, 8'h41);

      // R9 timeout on read, R10 code cleared on next launch
      load(16'h0550, 32'h2468_ACE0);
      exp_q.push_back({1'b0, 16'h0550, 32'h2468_ACE0});
      hwr(8'h3F, 8'h40);
      hrd(8'h3F, c); chk(c == 8'hC0, "R10 code cleared", c, 8'hC0);
      for (int k = 0; k < TMO; k++) @(negedge clk);
      hrd(8'h3F, c); chk(c == 8'hC0, "R9 still busy at limit", c, 8'hC0);
      @(negedge clk);
      hrd(8'h3F, c); chk(c == 8'h42, "R9 timeout code", c, 8'h42);
      rd32(v); chk(v == 32'h2468_ACE0, "R9 data kept", v, 32'h2468_ACE0);

      chk(exp_q.size() == 0, "R3 all requests seen", 64'(exp_q.size()), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule